// File: doc/BRIEF.md
# Flash Block Protection Controller

This block keeps the write-protection state of every erase block in a nonvolatile array that is divided into `NUM_BLOCKS` blocks. Bus writes carry a command byte and a block number. A setup byte followed by a second byte locks, unlocks or permanently locks ("locks down") the block named in the second write. Each block stores two bits: a lock bit and a lock-down bit. A hardware write-protect pin, active low, decides whether lock-down blocks are frozen. While the pin is high, lock-down blocks may be unlocked and locked again. When the pin falls, every lock-down block is forced back to locked.

For each block number presented on `chk_blk`, the block gives a program/erase permit flag. It also reports the two protection bits of a block when software reads that block's status location in identifier mode. The pin is synchronised inside the block, so it may change at any time relative to the clock.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After a synchronous reset, every block is locked and has its lock-down bit clear. The controller is in array mode with no setup pending, and `pe_ok`, `rd_valid`, `rd_data` and `seq_err` are 0.
- R2: One cycle after a block number is held on `chk_blk`, `pe_ok` is 1 exactly when that block's lock bit is 0. These are the states {pin, lock-down, lock} = 000, 100 and 110.
- R3: Writing 60h and then 01h sets the lock bit of the block given with the second write. Writing 60h and then D0h clears it.
- R4: Writing 60h and then 2Fh sets both the lock-down bit and the lock bit of the target block. Only reset clears a lock-down bit.
- R5: While the synchronised pin is low, a lock-down block ignores the lock, unlock and lock-down commands.
- R6: While the synchronised pin is high, a lock-down block can be unlocked (state 110) and locked again (state 111).
- R7: The pin passes through two flip-flops. In the single cycle where the synchronised level goes from 1 to 0, every block with its lock-down bit set gets its lock bit forced to 1. This overrides a command to that block in the same cycle.
- R8: After 60h, a second byte other than 01h, D0h or 2Fh changes no state, ends the sequence, and pulses `seq_err` for one cycle in the next cycle.
- R9: Writing 90h enters identifier mode. In that mode, a read with `rd_ofs` = 2 returns the lock bit on bit 0 and the lock-down bit on bit 1, with every other bit 0. Reads at any other offset return 0. `rd_valid` follows `rd_en` by one cycle.
- R10: Writing FFh returns to array mode, where every read returns 0. A first byte other than 60h, 90h or FFh has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin, active low, asynchronous |
| wr_en | input | 1 | Bus write strobe |
| wr_cmd | input | 8 | Command byte of the write |
| wr_blk | input | BLK_W | Block number of the write |
| rd_en | input | 1 | Bus read strobe |
| rd_blk | input | BLK_W | Block number of the read |
| rd_ofs | input | OFS_W | Word offset inside the block |
| chk_blk | input | BLK_W | Block whose permit is queried |
| pe_ok | output | 1 | Program/erase permitted for `chk_blk` (registered) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| seq_err | output | 1 | Pulse after a bad second byte |

## Verification
The hardest case is a snap-back that lands in the same cycle as a command on the second write of a sequence. Example: an unlock to a lock-down block on the exact edge where the synchronised pin first reads low. The bench provokes this by dropping `wp_n` and then issuing setup/unlock pairs at every phase offset against the three-flop pipeline. It also injects random pin toggles during dense command traffic. A behavioural reference model judges every cycle. It tracks the synchroniser stages and applies the command first and the snap-back after it, so the forced lock always wins.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam logic [7:0] CMD_SETUP  = 8'h60;
  localparam logic [7:0] CMD_LOCK   = 8'h01;
  localparam logic [7:0] CMD_UNLOCK = 8'hD0;
  localparam logic [7:0] CMD_LDOWN  = 8'h2F;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_LOCK,
    OP_UNLOCK,
    OP_LDOWN
  } lock_op_e;
endpackage

// File: rtl/flc_wp_sync.sv
module flc_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wp_n_i,
  output logic wp_eff_o,
  output logic wp_fall_o
);
  // sh[0..STAGES-1] synchroniser, sh[STAGES] previous synchronised level
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], wp_n_i};
  end

  assign wp_eff_o  = sh[STAGES-1];
  assign wp_fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/flc_cmd_dec.sv
module flc_cmd_dec
  import flc_pkg::*;
#(
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_cmd,
  input  logic [BW-1:0] wr_blk,
  output lock_op_e      op_o,
  output logic [BW-1:0] op_blk_o,
  output logic          id_mode_o,
  output logic          seq_err_o
);
  logic pend_q;

  always_comb begin
    op_o = OP_NONE;
    if (wr_en && pend_q) begin
      case (wr_cmd)
        CMD_LOCK:   op_o = OP_LOCK;
        CMD_UNLOCK: op_o = OP_UNLOCK;
        CMD_LDOWN:  op_o = OP_LDOWN;
        default:    op_o = OP_NONE;
      endcase
    end
  end

  assign op_blk_o = wr_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      id_mode_o <= 1'b0;
      seq_err_o <= 1'b0;
    end else begin
      seq_err_o <= 1'b0;
      if (wr_en) begin
        if (pend_q) begin
          pend_q    <= 1'b0;
          seq_err_o <= (op_o == OP_NONE);
        end else begin
          case (wr_cmd)
            CMD_SETUP: pend_q    <= 1'b1;
            CMD_IDENT: id_mode_o <= 1'b1;
            CMD_ARRAY: id_mode_o <= 1'b0;
            default:   ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flc_lock_bank.sv
module flc_lock_bank
  import flc_pkg::*;
#(
  parameter int NB = 32,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  lock_op_e      op_i,
  input  logic [BW-1:0] op_blk_i,
  input  logic          wp_eff_i,
  input  logic          wp_fall_i,
  output logic [NB-1:0] lock_o,
  output logic [NB-1:0] ldn_o
);
  for (genvar g = 0; g < NB; g++) begin : g_blk
    logic hit;
    logic frozen;
    assign hit    = (op_blk_i == BW'(g));
    assign frozen = ldn_o[g] & ~wp_eff_i;

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_o[g] <= 1'b1;
        ldn_o[g]  <= 1'b0;
      end else begin
        if (hit && !frozen) begin
          case (op_i)
            OP_LOCK:   lock_o[g] <= 1'b1;
            OP_UNLOCK: lock_o[g] <= 1'b0;
            OP_LDOWN: begin
              lock_o[g] <= 1'b1;
              ldn_o[g]  <= 1'b1;
            end
            default: ;
          endcase
        end
        // snap-back overrides any same-cycle command
        if (wp_fall_i && ldn_o[g]) lock_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flc_pkg::*;
#(
  parameter int NUM_BLOCKS = 32,
  parameter int DATA_W     = 16,
  parameter int OFS_W      = 4,
  parameter int STATUS_OFS = 2,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_cmd,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic              rd_en,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [OFS_W-1:0]  rd_ofs,
  input  logic [BLK_W-1:0]  chk_blk,
  output logic              pe_ok,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              seq_err
);
  localparam logic [OFS_W-1:0] STAT_OFS = OFS_W'(STATUS_OFS);

  lock_op_e              op;
  logic [BLK_W-1:0]      op_blk;
  logic                  id_mode;
  logic                  wp_eff;
  logic                  wp_fall;
  logic [NUM_BLOCKS-1:0] lock_q;
  logic [NUM_BLOCKS-1:0] ldn_q;

  flc_wp_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .wp_n_i(wp_n),
    .wp_eff_o(wp_eff), .wp_fall_o(wp_fall)
  );

  flc_cmd_dec #(.BW(BLK_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_blk(wr_blk),
    .op_o(op), .op_blk_o(op_blk), .id_mode_o(id_mode), .seq_err_o(seq_err)
  );

  flc_lock_bank #(.NB(NUM_BLOCKS), .BW(BLK_W)) u_bank (
    .clk(clk), .rst(rst), .op_i(op), .op_blk_i(op_blk),
    .wp_eff_i(wp_eff), .wp_fall_i(wp_fall),
    .lock_o(lock_q), .ldn_o(ldn_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_ok    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pe_ok    <= ~lock_q[chk_blk];
      rd_valid <= rd_en;
      rd_data  <= '0;
      if (rd_en && id_mode && (rd_ofs == STAT_OFS))
        rd_data <= {{(DATA_W-2){1'b0}}, ldn_q[rd_blk], lock_q[rd_blk]};
    end
  end
endmodule

// File: rtl/flc_checker.sv
module flc_checker #(
  parameter int NB = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wp_eff,
  input logic          wp_fall,
  input logic [NB-1:0] lock_q,
  input logic [NB-1:0] ldn_q,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          seq_err,
  input logic          wr_en
);
  // R7
  ldn_open_only_wp_high_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ldn_q & ~lock_q)) |-> (wp_eff || wp_fall));

  // R4
  ldn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ldn_q & $past(ldn_q)) == $past(ldn_q)));

  // R5
  ldn_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!wp_eff && !wp_fall) |=> ((lock_q & $past(ldn_q)) == ($past(lock_q) & $past(ldn_q))));

  // R8
  seq_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> $past(wr_en));

  // R9
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[DW-1:2] == '0);

  // R9
  rd_data_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data != '0) |-> rd_valid);
endmodule

bind flash_lock_ctrl flc_checker #(.NB(NUM_BLOCKS), .DW(DATA_W)) u_flc_chk (
  .clk(clk), .rst(rst), .wp_eff(wp_eff), .wp_fall(wp_fall),
  .lock_q(lock_q), .ldn_q(ldn_q), .rd_valid(rd_valid), .rd_data(rd_data),
  .seq_err(seq_err), .wr_en(wr_en)
);

// File: tb/flash_lock_ctrl_tb.sv
`timescale 1ns/1ps
module flash_lock_ctrl_tb;
  localparam int NB = 32;
  localparam int BW = 5;

  logic clk = 0;
  logic rst = 1;
  logic wp_n = 0;
  logic wr_en = 0;
  logic [7:0] wr_cmd = 0;
  logic [BW-1:0] wr_blk = 0;
  logic rd_en = 0;
  logic [BW-1:0] rd_blk = 0;
  logic [3:0] rd_ofs = 0;
  logic [BW-1:0] chk_blk = 0;
  logic pe_ok, rd_valid, seq_err;
  logic [15:0] rd_data;

  always #2 clk = ~clk;

  flash_lock_ctrl u_dut (
    .clk(clk), .rst(rst), .wp_n(wp_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .wr_blk(wr_blk), .rd_en(rd_en), .rd_blk(rd_blk), .rd_ofs(rd_ofs),
    .chk_blk(chk_blk), .pe_ok(pe_ok), .rd_valid(rd_valid),
    .rd_data(rd_data), .seq_err(seq_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference model
  bit m_lock[NB];
  bit m_ldn[NB];
  bit m_pend, m_id, m_s1, m_s2, m_s3;
  bit e_pe, e_rv, e_err;
  logic [15:0] e_rd = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_lock[i]) begin m_lock[i] = 1; m_ldn[i] = 0; end
      m_pend = 0; m_id = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      e_pe = 0; e_rv = 0; e_err = 0; e_rd = 0;
    end else begin
      bit wpe, fall;
      int b;
      e_pe = !m_lock[int'(chk_blk)];
      e_rv = rd_en;
      e_rd = 0;
      if (rd_en && m_id && rd_ofs == 2) e_rd = {14'd0, m_ldn[int'(rd_blk)], m_lock[int'(rd_blk)]};
      wpe = m_s2;
      fall = m_s3 && !m_s2;
      e_err = 0;
      b = int'(wr_blk);
      if (wr_en) begin
        if (m_pend) begin
          m_pend = 0;
          if (wr_cmd == 8'h01 || wr_cmd == 8'hD0 || wr_cmd == 8'h2F) begin
            if (!(m_ldn[b] && !wpe)) begin
              if (wr_cmd == 8'h01) m_lock[b] = 1;
              else if (wr_cmd == 8'hD0) m_lock[b] = 0;
              else begin m_lock[b] = 1; m_ldn[b] = 1; end
            end
          end else e_err = 1;
        end else if (wr_cmd == 8'h60) m_pend = 1;
        else if (wr_cmd == 8'h90) m_id = 1;
        else if (wr_cmd == 8'hFF) m_id = 0;
      end
      if (fall) foreach (m_lock[i]) if (m_ldn[i]) m_lock[i] = 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = wp_n;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check(cur_req, {15'd0, pe_ok}, {15'd0, e_pe}, "pe_ok vs model (R2)");
    check(cur_req, {15'd0, rd_valid}, {15'd0, e_rv}, "rd_valid vs model (R9)");
    check(cur_req, rd_data, e_rd, "rd_data vs model (R9)");
    check(cur_req, {15'd0, seq_err}, {15'd0, e_err}, "seq_err vs model (R8)");
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(logic [7:0] c, int blk);
    wr_en = 1; wr_cmd = c; wr_blk = BW'(blk);
    cyc();
    wr_en = 0;
  endtask

  task automatic seq(logic [7:0] c, int blk);
    wr(8'h60, blk);
    wr(c, blk);
  endtask

  task automatic status(int blk, logic [3:0] ofs, logic [15:0] exp, string req);
    rd_en = 1; rd_blk = BW'(blk); rd_ofs = ofs;
    cyc();
    rd_en = 0;
    check(req, rd_data, exp, "status read");
  endtask

  task automatic perm(int blk, bit exp, string req);
    chk_blk = BW'(blk);
    cyc();
    check(req, {15'd0, pe_ok}, {15'd0, exp}, "permit");
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) cyc();
    rst = 0;
    // R1: reset defaults
    cur_req = "R1";
    check("R1", {15'd0, pe_ok}, 16'd0, "pe_ok after reset");
    perm(0, 0, "R1");
    wr(8'h90, 0);
    status(7, 2, 16'h0001, "R1");

    cur_req = "R3";
    seq(8'hD0, 3);
    perm(3, 1, "R3");
    status(3, 2, 16'h0000, "R3");
    seq(8'h01, 3);
    perm(3, 0, "R3");
    status(3, 2, 16'h0001, "R3");
    status(3, 0, 16'h0000, "R9");
    status(3, 3, 16'h0000, "R9");

    cur_req = "R4";
    seq(8'hD0, 5);
    seq(8'h2F, 5);
    status(5, 2, 16'h0003, "R4");

    cur_req = "R5";
    seq(8'hD0, 5);
    seq(8'h01, 5);
    status(5, 2, 16'h0003, "R5");
    perm(5, 0, "R5");

    cur_req = "R6";
    wp_n = 1;
    repeat (4) cyc();
    seq(8'hD0, 5);
    status(5, 2, 16'h0002, "R6");
    perm(5, 1, "R6");
    seq(8'h01, 5);
    status(5, 2, 16'h0003, "R6");
    seq(8'hD0, 5);
    seq(8'h2F, 9);
    seq(8'hD0, 9);
    status(9, 2, 16'h0002, "R6");

    // R7: snap-back with commands at every phase around the falling edge
    cur_req = "R7";
    for (int off = 0; off < 4; off++) begin
      seq(8'hD0, 5);
      seq(8'hD0, 9);
      wp_n = 1;
      repeat (4) cyc();
      seq(8'hD0, 5);
      wp_n = 0;
      repeat (off) cyc();
      for (int k = 0; k < 3; k++) seq(8'hD0, (k % 2) ? 9 : 5);
      status(5, 2, 16'h0003, "R7");
      status(9, 2, 16'h0003, "R7");
      perm(9, 0, "R7");
    end

    cur_req = "R8";
    seq(8'hD0, 12);
    wr(8'h60, 12);
    wr(8'h55, 12);
    check("R8", {15'd0, seq_err}, 16'd1, "seq_err pulse");
    cyc();
    check("R8", {15'd0, seq_err}, 16'd0, "seq_err single");
    perm(12, 1, "R8");
    wr(8'h01, 12);
    perm(12, 1, "R8");

    cur_req = "R10";
    wr(8'hFF, 0);
    status(12, 2, 16'h0000, "R10");
    wr(8'h90, 0);
    wr(8'h42, 0);
    status(12, 2, 16'h0000, "R10");
    wr(8'h90, 0);

    cur_req = "R1";
    rst = 1; cyc(); rst = 0; wp_n = 0;
    wr(8'h90, 0);
    status(5, 2, 16'h0001, "R1");
    status(12, 2, 16'h0001, "R1");

    // mixed random traffic judged by the model
    cur_req = "R7";
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      wr_en = ($urandom_range(0, 2) != 0);
      case (r)
        0, 1, 2: wr_cmd = 8'h60;
        3: wr_cmd = 8'h01;
        4, 5: wr_cmd = 8'hD0;
        6: wr_cmd = 8'h2F;
        7: wr_cmd = 8'h90;
        8: wr_cmd = 8'hFF;
        default: wr_cmd = 8'($urandom);
      endcase
      wr_blk = BW'($urandom_range(0, 3));
      rd_en = $urandom_range(0, 1);
      rd_blk = BW'($urandom_range(0, 3));
      rd_ofs = ($urandom_range(0, 3) != 0) ? 4'd2 : 4'($urandom);
      chk_blk = BW'($urandom_range(0, 3));
      if ($urandom_range(0, 14) == 0) wp_n = ~wp_n;
      rst = ($urandom_range(0, 999) == 0);
      cyc();
    end
    rst = 0; wr_en = 0; rd_en = 0;
    cyc();
    finish_run();
  end
endmodule